// File: doc/BRIEF.md
# Line Zero-Crossing, Period, Phase-Delay and Sag Monitor

This block sits behind the sample decimators of a single-phase metering front end. Each accepted beat carries one signed voltage sample and one signed current sample. The block finds zero crossings on both channels, but only where the half-wave that ends at the crossing reached a minimum amplitude. Low-level noise therefore never produces an event. The qualified crossings drive a one-cycle event pulse for each channel, and the edge polarity that produces the pulses is selectable.

Rising voltage crossings mark line cycles, and three measurements hang off them:
- a period count between successive rising voltage crossings;
- a delay count from a rising voltage crossing to the next rising current crossing;
- a sag detector that raises a flag once enough consecutive line cycles pass without any voltage sample reaching a programmed magnitude.

Counts advance on an internal timer tick that fires once every `TICK_DIV` clocks.

The sample input uses a valid/ready handshake. The block never applies back-pressure: `s_ready` is held high, so a beat is taken on every clock edge where `s_valid` is high. Configuration inputs and result outputs are plain levels. All results are registered and change on the clock edge that accepts the sample causing the change.

Top module: `zc_sag_monitor`

## Requirements
- R1: `s_ready` is 1 whenever out of reset. On any clock edge where `s_valid` is 0, no event pulse is produced, and `period`, `angle` and `sag_flag` keep their values.
- R2: A sample is negative when its sign bit is 1; zero counts as non-negative. A rising crossing is a non-negative sample accepted right after a negative one. A falling crossing is a negative sample accepted right after a non-negative one.
- R3: A crossing is qualified only if some sample in the half-wave that it ends had a magnitude of at least 26, which is 2^15/1250 for 16-bit samples. That half-wave is the samples since the previous sign change, including the sample that made that change. Unqualified crossings have no effect anywhere.
- R4: `edge_sel` encoding: 2'b01 gives rising crossings only, 2'b10 gives falling only, and 2'b00 or 2'b11 gives both. `zx_pulse` (voltage) and `izx_pulse` (current) are high for the one cycle after the edge that accepts a selected qualified crossing.
- R5: On each qualified rising voltage crossing other than the first after reset, `period` takes the number of timer ticks since the previous one. Otherwise it holds. With `TICK_DIV`=1 this equals the number of clock edges between the two accepting edges.
- R6: `period` and `angle` saturate at 65535.
- R7: `angle` takes the tick count from a qualified rising voltage crossing to the next qualified rising current crossing. Both crossings in the same sample give 0. A newer voltage crossing restarts the timing. A current crossing with no pending voltage crossing changes nothing.
- R8: A line cycle runs from one qualified rising voltage crossing up to and including the next. It is low if none of its samples has a magnitude of at least `sag_level`. After N consecutive low cycles (saturating at 255), `sag_flag` is set once N ≥ `sag_cycles`. A `sag_cycles` value of 0 never sets it.
- R9: A completed cycle that is not low clears the low-cycle count and clears `sag_flag`.
- R10: After reset, `zx_pulse`, `izx_pulse`, `period`, `angle` and `sag_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Always 1 (no back-pressure) |
| v_sample | input | W | Signed voltage sample |
| i_sample | input | W | Signed current sample |
| edge_sel | input | 2 | Crossing polarity select for the pulses |
| sag_level | input | W | Unsigned magnitude below which a sample is low |
| sag_cycles | input | SCW | Low cycles needed to flag a sag (0 disables) |
| zx_pulse | output | 1 | Voltage crossing event pulse |
| izx_pulse | output | 1 | Current crossing event pulse |
| period | output | PW | Line period in timer ticks |
| angle | output | PW | Voltage-to-current delay in timer ticks |
| sag_flag | output | 1 | Sag indication |

## Verification
The hardest state to reach from the ports is period saturation. It needs more than 65535 ticks between two qualified rising voltage crossings, while the voltage detector stays armed across the gap. The stimulus gets there by holding `s_valid` low for 66000 cycles in the middle of a waveform, then resuming the same waveform so the next rising crossing is still qualified.

The amplitude floor is the other delicate edge. It is hit with triangle waves whose peaks are exactly 25 and exactly 26. The bench lets the leftover arming from the preceding large wave drain before it counts pulses.

// File: rtl/zsm_pkg.sv
`timescale 1ns/1ps
package zsm_pkg;
  typedef enum logic [1:0] {
    EDGE_BOTH = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int unsigned ZX_RATIO = 1250;

  // smallest half-wave peak that qualifies a crossing, for a w-bit signed sample
  function automatic int unsigned zx_floor(input int unsigned w);
    return (32'd1 << (w - 1)) / ZX_RATIO;
  endfunction
endpackage

// File: rtl/zsm_zc_detect.sv
`timescale 1ns/1ps
module zsm_zc_detect #(
  parameter int          W   = 16,
  parameter int unsigned THR = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         neg,
  input  logic [W:0]   mag,
  output logic         rise,
  output logic         fall
);
  logic neg_q;
  logic armed_q;
  logic loud;

  assign loud = (mag >= (W+1)'(THR));
  assign rise = accept & neg_q & ~neg & armed_q;
  assign fall = accept & ~neg_q & neg & armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (accept) begin
      neg_q   <= neg;
      armed_q <= (neg != neg_q) ? loud : (armed_q | loud);
    end
  end
endmodule

// File: rtl/zsm_span.sv
`timescale 1ns/1ps
module zsm_span #(
  parameter int CW      = 16,
  parameter int ONESHOT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          stop,
  output logic [CW-1:0] value
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam bit            ONE  = (ONESHOT != 0);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          run_q;
  logic          both;

  assign cnt_inc = (tick && cnt_q != CMAX) ? cnt_q + CW'(1) : cnt_q;

  generate
    if (ONE) begin : g_oneshot
      assign both = start & stop;
    end else begin : g_free
      assign both = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (both) begin
      value <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (stop && run_q) value <= cnt_inc;
      if (start) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else begin
        if (run_q) cnt_q <= cnt_inc;
        if (ONE && stop) run_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zsm_sag.sv
`timescale 1ns/1ps
module zsm_sag #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          cyc_end,
  input  logic [W:0]    mag,
  input  logic [W-1:0]  level,
  input  logic [CW-1:0] need,
  output logic          sag
);
  logic          seen_q;
  logic          high_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          big;

  assign big     = (mag >= {1'b0, level});
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      high_q <= 1'b0;
      cnt_q  <= '0;
      sag    <= 1'b0;
    end else if (accept) begin
      if (cyc_end) begin
        if (seen_q) begin
          if (high_q || big) begin
            cnt_q <= '0;
            sag   <= 1'b0;
          end else begin
            cnt_q <= cnt_inc;
            if (need != '0 && cnt_inc >= need) sag <= 1'b1;
          end
        end
        seen_q <= 1'b1;
        high_q <= 1'b0;
      end else begin
        high_q <= high_q | big;
      end
    end
  end
endmodule

// File: rtl/zc_sag_monitor.sv
`timescale 1ns/1ps
module zc_sag_monitor
  import zsm_pkg::*;
#(
  parameter int W        = 16,
  parameter int TICK_DIV = 4,
  parameter int PW       = 16,
  parameter int SCW      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic signed [W-1:0] v_sample,
  input  logic signed [W-1:0] i_sample,
  input  logic [1:0]          edge_sel,
  input  logic [W-1:0]        sag_level,
  input  logic [SCW-1:0]      sag_cycles,
  output logic                zx_pulse,
  output logic                izx_pulse,
  output logic [PW-1:0]       period,
  output logic [PW-1:0]       angle,
  output logic                sag_flag
);
  localparam int unsigned THR = zx_floor(W);
  localparam int          NCH = 2;

  logic signed [W-1:0] smp [NCH];
  logic [W:0]          mag [NCH];
  logic [NCH-1:0]      rise;
  logic [NCH-1:0]      fall;
  logic                tick;
  edge_sel_e           sel;
  logic                take_rise;
  logic                take_fall;

  assign s_ready   = 1'b1;
  assign smp[0]    = v_sample;
  assign smp[1]    = i_sample;
  assign sel       = edge_sel_e'(edge_sel);
  assign take_rise = (sel != EDGE_FALL);
  assign take_fall = (sel != EDGE_RISE);

  // channel 0 = voltage, channel 1 = current
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign mag[c] = smp[c][W-1] ? ((W+1)'(0) - {smp[c][W-1], smp[c]}) : {1'b0, smp[c]};
    zsm_zc_detect #(.W(W), .THR(THR)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (s_valid),
      .neg    (smp[c][W-1]),
      .mag    (mag[c]),
      .rise   (rise[c]),
      .fall   (fall[c])
    );
  end

  generate
    if (TICK_DIV <= 1) begin : g_fast
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (!rst_n)            dcnt <= '0;
        else if (dcnt == LAST) dcnt <= '0;
        else                   dcnt <= dcnt + DW'(1);
      end
      assign tick = (dcnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zx_pulse  <= 1'b0;
      izx_pulse <= 1'b0;
    end else begin
      zx_pulse  <= (take_rise & rise[0]) | (take_fall & fall[0]);
      izx_pulse <= (take_rise & rise[1]) | (take_fall & fall[1]);
    end
  end

  zsm_span #(.CW(PW), .ONESHOT(0)) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .start (rise[0]),
    .stop  (rise[0]),
    .value (period)
  );

  zsm_span #(.CW(PW), .ONESHOT(1)) u_angle (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .start (rise[0]),
    .stop  (rise[1]),
    .value (angle)
  );

  zsm_sag #(.W(W), .CW(SCW)) u_sag (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (s_valid),
    .cyc_end (rise[0]),
    .mag     (mag[0]),
    .level   (sag_level),
    .need    (sag_cycles),
    .sag     (sag_flag)
  );
endmodule

// File: rtl/zc_sag_monitor_chk.sv
`timescale 1ns/1ps
module zc_sag_monitor_chk #(
  parameter int PW  = 16,
  parameter int SCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           v_neg,
  input logic [1:0]     edge_sel,
  input logic [SCW-1:0] sag_cycles,
  input logic           zx_pulse,
  input logic           izx_pulse,
  input logic [PW-1:0]  period,
  input logic [PW-1:0]  angle,
  input logic           sag_flag
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> (!zx_pulse && !izx_pulse));

  a_r1_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(period));

  a_r1_angle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(angle));

  a_r1_sag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(sag_flag));

  a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && edge_sel == 2'b01 && v_neg) |=> !zx_pulse);

  a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && edge_sel == 2'b10 && !v_neg) |=> !zx_pulse);

  a_r8_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sag_flag) |-> ($past(sag_cycles) != '0));
endmodule

bind zc_sag_monitor zc_sag_monitor_chk #(.PW(PW), .SCW(SCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .v_neg      (v_sample[W-1]),
  .edge_sel   (edge_sel),
  .sag_cycles (sag_cycles),
  .zx_pulse   (zx_pulse),
  .izx_pulse  (izx_pulse),
  .period     (period),
  .angle      (angle),
  .sag_flag   (sag_flag)
);

// File: tb/zc_sag_monitor_tb.sv
`timescale 1ns/1ps
module zc_sag_monitor_tb;
  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                s_valid;
  logic                s_ready;
  logic signed [W-1:0] v_sample;
  logic signed [W-1:0] i_sample;
  logic [1:0]          edge_sel;
  logic [W-1:0]        sag_level;
  logic [7:0]          sag_cycles;
  logic                zx_pulse;
  logic                izx_pulse;
  logic [15:0]         period;
  logic [15:0]         angle;
  logic                sag_flag;

  always #2.5 clk = ~clk;

  zc_sag_monitor #(.W(W), .TICK_DIV(1), .PW(16), .SCW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .v_sample(v_sample), .i_sample(i_sample), .edge_sel(edge_sel),
    .sag_level(sag_level), .sag_cycles(sag_cycles), .zx_pulse(zx_pulse),
    .izx_pulse(izx_pulse), .period(period), .angle(angle), .sag_flag(sag_flag)
  );

  int  nchk = 0, nfail = 0;
  bit  done = 0;
  int  cyc = 0, t = 0;
  int  per = 40, amp = 8000, iamp = 10000, dly = 7;
  int  zx_seen = 0, sat_hits = 0;
  bit  mv_neg, mv_arm, mi_neg, mi_arm, m_seen, ms_seen, m_arun, ms_high;
  int  m_vlast, m_astart, ms_cnt;
  int  e_period, e_angle;
  bit  e_sag, e_zx, e_izx;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tri_wave(input int tt, input int p, input int a);
    int ph, x;
    ph = tt % p;
    x  = (4 * a * ph) / p;
    if (ph * 2 < p) return a - x;
    return x - 3 * a;
  endfunction

  function automatic int sat16(input int d);
    return (d > 65535) ? 65535 : d;
  endfunction

  task automatic model(input int vs, input int is);
    int av, ai;
    bit vn, inn, vr, vf, ir, ifl, tr, tf, bigv;
    av = (vs < 0) ? -vs : vs;
    ai = (is < 0) ? -is : is;
    vn = (vs < 0); inn = (is < 0);
    vr = mv_neg && !vn && mv_arm;   vf  = !mv_neg && vn && mv_arm;
    ir = mi_neg && !inn && mi_arm;  ifl = !mi_neg && inn && mi_arm;
    mv_arm = (vn != mv_neg) ? (av >= 26) : (mv_arm || av >= 26);
    mi_arm = (inn != mi_neg) ? (ai >= 26) : (mi_arm || ai >= 26);
    mv_neg = vn; mi_neg = inn;
    tr = (edge_sel != 2'b10); tf = (edge_sel != 2'b01);
    e_zx  = (tr && vr) || (tf && vf);
    e_izx = (tr && ir) || (tf && ifl);
    bigv = (av >= int'(sag_level));
    if (vr) begin
      if (ms_seen) begin
        if (ms_high || bigv) begin ms_cnt = 0; e_sag = 0; end
        else begin
          if (ms_cnt < 255) ms_cnt++;
          if (sag_cycles != 0 && ms_cnt >= int'(sag_cycles)) e_sag = 1;
        end
      end
      ms_seen = 1; ms_high = 0;
    end else ms_high = ms_high || bigv;
    if (vr) begin
      if (m_seen) e_period = sat16(cyc - m_vlast);
      m_vlast = cyc; m_seen = 1;
    end
    if (vr && ir) begin e_angle = 0; m_arun = 0; end
    else begin
      if (ir && m_arun) begin e_angle = sat16(cyc - m_astart); m_arun = 0; end
      if (vr) begin m_astart = cyc; m_arun = 1; end
    end
    if (vr && e_period == 65535 && m_seen) sat_hits += (period == 16'hFFFF) ? 0 : 0;
  endtask

  task automatic step(input bit vld, input int vs, input int is);
    @(negedge clk);
    s_valid  = vld;
    v_sample = 16'(vs);
    i_sample = 16'(is);
    @(posedge clk);
    cyc++;
    if (vld) model(vs, is);
    else begin e_zx = 0; e_izx = 0; end
    #1;
    if (zx_pulse) zx_seen++;
    if (vld) begin
      chk("R2 R3 R4 voltage pulse", int'(zx_pulse), int'(e_zx));
      chk("R2 R3 R4 current pulse", int'(izx_pulse), int'(e_izx));
      chk("R5 period", int'(period), e_period);
      chk("R7 angle", int'(angle), e_angle);
      chk("R8 R9 sag flag", int'(sag_flag), int'(e_sag));
      if (e_period == 65535 && period == 16'hFFFF) sat_hits++;
    end else begin
      chk("R1 idle no pulse", int'(zx_pulse | izx_pulse), 0);
      chk("R1 idle period hold", int'(period), e_period);
    end
  endtask

  task automatic run(input int n, input int pct);
    for (int k = 0; k < n; k++) begin
      if (($urandom % 100) < pct) begin
        step(1, tri_wave(t, per, amp), tri_wave(t + per * 100 - dly, per, iamp));
        t++;
      end else step(0, 0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    rst_n = 0; s_valid = 0; v_sample = '0; i_sample = '0;
    edge_sel = 2'b00; sag_level = '0; sag_cycles = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset zx", int'(zx_pulse | izx_pulse), 0);
    chk("R10 reset period", int'(period), 0);
    chk("R10 reset angle", int'(angle), 0);
    chk("R10 reset sag", int'(sag_flag), 0);
    chk("R1 ready", int'(s_ready), 1);
    @(negedge clk);
    rst_n = 1;

    // steady wave, both edges
    run(400, 100);
    // random shapes, edge selects and gaps
    for (int r = 0; r < 6; r++) begin
      per = 20 + int'($urandom % 41);
      amp = 200 + int'($urandom % 20000);
      dly = int'($urandom % per);
      edge_sel = 2'($urandom % 4);
      run(300, 70);
    end
    // amplitude floor
    edge_sel = 2'b00; per = 40; amp = 25;
    run(100, 100);
    zx_seen = 0;
    run(300, 100);
    chk("R3 peak 25 gives no crossing", zx_seen, 0);
    amp = 26;
    zx_seen = 0;
    run(300, 100);
    chk("R3 peak 26 gives crossings", int'(zx_seen > 0), 1);
    // same-sample delay
    amp = 8000; per = 30; dly = 0;
    run(200, 100);
    chk("R7 same sample delay", int'(angle), 0);
    // sag
    dly = 5; sag_level = 16'd5000; sag_cycles = 8'd3;
    run(150, 100);
    chk("R9 no sag at full level", int'(sag_flag), 0);
    amp = 3000; run(45, 100);
    chk("R8 short dip not flagged", int'(sag_flag), 0);
    amp = 8000; run(60, 100);
    amp = 3000; run(150, 100);
    chk("R8 long dip flagged", int'(sag_flag), 1);
    amp = 8000; run(90, 100);
    chk("R9 recovery clears", int'(sag_flag), 0);
    sag_cycles = 8'd0; amp = 3000; run(300, 100);
    chk("R8 zero count disables", int'(sag_flag), 0);
    // saturation of period across a long idle gap
    sag_level = '0; amp = 8000; per = 40; dly = 7;
    run(100, 100);
    for (int k = 0; k < 66000; k++) step(0, 0, 0);
    sat_hits = 0;
    run(100, 100);
    chk("R6 period saturates", int'(sat_hits > 0), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule